// File: doc/BRIEF.md
# Half/Single Precision Format Converter

This block converts floating-point values between IEEE binary16 (half) and binary32 (single) in either direction. One control bit picks the direction. Operands come in and results go out on 32-bit words, and a half value always sits in bits 15..0. Each accepted operand produces a registered result one clock later. The result carries four exception indications: invalid, overflow, underflow and inexact.

Half values widen to single without any loss. A half denormal becomes a normalised single. Narrowing a single to half rounds to nearest, ties to even. The rounding saturates to signed infinity on overflow and produces half denormals or zero for tiny values. Neither direction flushes denormal inputs to zero. NaNs do not use the usual truncated payload. The two most significant payload bits and the eight least significant payload bits move as two separate fields. A signaling NaN keeps its quiet bit clear in the result and raises invalid.

Top module: `hsc_converter`

## Requirements
- R1: With `to_half`=0, every finite half input (zero, denormal or normal) gives the single of identical value and sign, with no flag raised.
- R2: A half infinity gives the single infinity of the same sign (exponent 0xFF, significand 0). A single infinity gives the half infinity of the same sign (0x7C00 magnitude). Neither raises a flag.
- R3: A half NaN (exponent 0x1F, significand nonzero) gives a single with the same sign and exponent 0xFF. Single bits 22..21 take half bits 9..8, single bits 7..0 take half bits 7..0, and single bits 20..8 are 0.
- R4: A single NaN gives a half with the same sign and exponent 0x1F. Half bits 9..8 take single bits 22..21, and half bits 7..0 take single bits 7..0. If those ten bits would all be 0, half bit 8 is set to 1.
- R5: A NaN whose quiet bit is 0 raises invalid. The quiet bit is half bit 9 or single bit 22. A quiet NaN raises no flag, and no non-NaN input raises invalid.
- R6: With `to_half`=1, finite singles round to nearest, ties to even. Inexact is set exactly when the rounded value differs from the input.
- R7: When the rounded magnitude of a single would reach 65536 or more, the result is a signed half infinity and both overflow and inexact are set.
- R8: When the input magnitude before rounding is below 2^-14 and the result is inexact, underflow and inexact are set and the result is a half denormal, zero, or the smallest normal. This includes nonzero single denormals, which round to signed zero.
- R9: A result appears on `dout` with `out_valid`=1 one cycle after `in_valid`=1. A cycle without `in_valid` gives `out_valid`=0 with `dout` and all flags at 0 in the following cycle.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `dout` and all flags become 0.
- R11: Half results have bits 31..16 of `dout` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present on `din` this cycle |
| to_half | input | 1 | 1: single to half, 0: half to single |
| din | input | 32 | Operand word (half in bits 15..0) |
| out_valid | output | 1 | Result present on `dout` |
| dout | output | 32 | Result word (half in bits 15..0) |
| flg_invalid | output | 1 | Signaling NaN consumed |
| flg_overflow | output | 1 | Rounded result too large for half |
| flg_underflow | output | 1 | Tiny and inexact result |
| flg_inexact | output | 1 | Result differs from exact value |

## Verification
Each result and all four flags become due one clock after the operand is accepted, since a single register stage follows the combinational conversion. The bench drives a new operand on every falling edge. At the next falling edge it compares the output of the operand driven one edge earlier, so the comparisons overlap the next operand without ever sampling at a rising edge. Expected half-to-single values come from real arithmetic on all 65536 half codes. Expected single-to-half values come from a real-valued round-to-nearest-even model applied to directed corner operands and random operands.

// File: rtl/hsc_pkg.sv
// Shared format constants and the exception flag bundle for the converter.
// Assumes IEEE binary16 and binary32 encodings with their standard biases.
package hsc_pkg;
    localparam int H_EXP_W  = 5;
    localparam int H_MAN_W  = 10;
    localparam int S_EXP_W  = 8;
    localparam int S_MAN_W  = 23;
    localparam int H_W      = 1 + H_EXP_W + H_MAN_W;
    localparam int S_W      = 1 + S_EXP_W + S_MAN_W;
    localparam int H_BIAS   = (1 << (H_EXP_W - 1)) - 1;
    localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
    localparam int DROP_W   = S_MAN_W - H_MAN_W;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } hsc_flags_t;
endpackage

// File: rtl/hsc_h2s.sv
// Combinational half-to-single widening. Always exact. Half denormals are
// normalised. NaN payload moves as a 2-bit top field and an 8-bit low field.
// Assumes the operand is presented in a 16-bit word.
module hsc_h2s
    import hsc_pkg::*;
(
    input  logic [H_W-1:0] h_in,
    output logic [S_W-1:0] s_out,
    output hsc_flags_t     fl
);
    logic                sgn;
    logic [H_EXP_W-1:0]  ex;
    logic [H_MAN_W-1:0]  mn;
    logic [3:0]          lead;
    logic [S_MAN_W:0]    tmp;

    // widen one half operand to single precision
    always_comb begin
        sgn   = h_in[H_W-1];
        ex    = h_in[H_W-2:H_MAN_W];
        mn    = h_in[H_MAN_W-1:0];
        s_out = '0;
        fl    = '0;
        lead  = '0;
        tmp   = '0;
        for (int i = 0; i < H_MAN_W; i++) begin
            if (mn[i]) lead = 4'(i);
        end
        if (ex == '1) begin
            if (mn == '0) begin
                s_out = {sgn, 8'hFF, 23'h0};
            end else begin
                s_out      = {sgn, 8'hFF, mn[9:8], 13'h0, mn[7:0]};
                fl.invalid = ~mn[9];
            end
        end else if (ex == '0) begin
            if (mn == '0) begin
                s_out = {sgn, 31'h0};
            end else begin
                tmp   = {14'h0, mn} << (5'd23 - {1'b0, lead});
                s_out = {sgn, 8'(8'(S_BIAS - H_BIAS - H_MAN_W + 1) + {4'h0, lead}), tmp[S_MAN_W-1:0]};
            end
        end else begin
            s_out = {sgn, 8'({3'b0, ex} + 8'(S_BIAS - H_BIAS)), mn, 13'h0};
        end
    end
endmodule

// File: rtl/hsc_s2h.sv
// Combinational single-to-half narrowing with round-to-nearest-even.
// Saturates to infinity on overflow and produces denormals for tiny values.
// Tininess is judged before rounding. NaN payload uses the split-field mapping.
module hsc_s2h
    import hsc_pkg::*;
(
    input  logic [S_W-1:0] s_in,
    output logic [H_W-1:0] h_out,
    output hsc_flags_t     fl
);
    logic                sgn;
    logic [S_EXP_W-1:0]  ex;
    logic [S_MAN_W-1:0]  fr;
    logic [S_MAN_W:0]    sig;
    logic signed [9:0]   unb;
    logic [5:0]          sh;
    logic [47:0]         t;
    logic [23:0]         kept;
    logic                rbit;
    logic                stk;
    logic                rup;
    logic [15:0]         mag;
    logic [H_MAN_W-1:0]  pay;

    // narrow one single operand to half precision
    always_comb begin
        sgn   = s_in[S_W-1];
        ex    = s_in[S_W-2:S_MAN_W];
        fr    = s_in[S_MAN_W-1:0];
        sig   = {1'b1, fr};
        unb   = signed'({2'b00, ex}) - 10'sd127;
        h_out = '0;
        fl    = '0;
        sh    = '0;
        t     = '0;
        kept  = '0;
        rbit  = 1'b0;
        stk   = 1'b0;
        rup   = 1'b0;
        mag   = '0;
        pay   = '0;
        if (ex == '1) begin
            if (fr == '0) begin
                h_out = {sgn, 5'h1F, 10'h0};
            end else begin
                pay = {fr[22:21], fr[7:0]};
                if (pay == '0) pay[8] = 1'b1;
                h_out      = {sgn, 5'h1F, pay};
                fl.invalid = ~fr[22];
            end
        end else if (ex == '0) begin
            h_out = {sgn, 15'h0};
            if (fr != '0) begin
                fl.underflow = 1'b1;
                fl.inexact   = 1'b1;
            end
        end else if (unb > 10'sd15) begin
            h_out       = {sgn, 5'h1F, 10'h0};
            fl.overflow = 1'b1;
            fl.inexact  = 1'b1;
        end else if (unb >= -10'sd14) begin
            rbit = fr[DROP_W-1];
            stk  = |fr[DROP_W-2:0];
            rup  = rbit & (stk | fr[DROP_W]);
            mag  = {1'b0, 5'(unb + 10'sd15), fr[S_MAN_W-1:DROP_W]} + 16'(rup);
            if (mag >= 16'h7C00) begin
                h_out       = {sgn, 5'h1F, 10'h0};
                fl.overflow = 1'b1;
                fl.inexact  = 1'b1;
            end else begin
                h_out      = {sgn, mag[14:0]};
                fl.inexact = rbit | stk;
            end
        end else begin
            sh   = (unb < -10'sd25) ? 6'd25 : 6'(-unb - 10'sd1);
            t    = {sig, 24'h0} >> sh;
            kept = t[47:24];
            rbit = t[23];
            stk  = |t[22:0];
            rup  = rbit & (stk | kept[0]);
            mag  = 16'(kept) + 16'(rup);
            h_out        = {sgn, mag[14:0]};
            fl.inexact   = rbit | stk;
            fl.underflow = rbit | stk;
        end
    end
endmodule

// File: rtl/hsc_converter.sv
// Top of the half/single converter. Selects the direction, registers the
// result and its flags one cycle after an accepted operand, and clears the
// outputs in idle cycles. Synchronous active-low reset.
module hsc_converter
    import hsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        to_half,
    input  logic [31:0] din,
    output logic        out_valid,
    output logic [31:0] dout,
    output logic        flg_invalid,
    output logic        flg_overflow,
    output logic        flg_underflow,
    output logic        flg_inexact
);
    logic [S_W-1:0] s_res;
    logic [H_W-1:0] h_res;
    hsc_flags_t     fl_h2s;
    hsc_flags_t     fl_s2h;
    hsc_flags_t     fl_q;

    hsc_h2s u_h2s (
        .h_in  (din[H_W-1:0]),
        .s_out (s_res),
        .fl    (fl_h2s)
    );

    hsc_s2h u_s2h (
        .s_in  (din),
        .h_out (h_res),
        .fl    (fl_s2h)
    );

    // capture the selected result and flags, clear them when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dout      <= '0;
            fl_q      <= '0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            dout      <= to_half ? {16'h0, h_res} : s_res;
            fl_q      <= to_half ? fl_s2h : fl_h2s;
        end else begin
            out_valid <= 1'b0;
            dout      <= '0;
            fl_q      <= '0;
        end
    end

    assign flg_invalid   = fl_q.invalid;
    assign flg_overflow  = fl_q.overflow;
    assign flg_underflow = fl_q.underflow;
    assign flg_inexact   = fl_q.inexact;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (dout == 32'h0 && !flg_invalid && !flg_overflow && !flg_underflow && !flg_inexact));

    // R7
    ovf_to_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flg_overflow |-> (dout[14:0] == 15'h7C00 && flg_inexact));

    // R8
    unf_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flg_underflow |-> (flg_inexact && dout[14:0] <= 15'h0400));

    // R11
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(to_half)) |-> dout[31:16] == 16'h0);

    // R1
    widen_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(to_half)) |-> (!flg_overflow && !flg_underflow && !flg_inexact));
endmodule

// File: tb/tb_hsc_converter.sv
`timescale 1ns/1ps
module tb_hsc_converter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        to_half = 1'b0;
    logic [31:0] din = '0;
    logic        out_valid;
    logic [31:0] dout;
    logic        flg_invalid, flg_overflow, flg_underflow, flg_inexact;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic        p_on = 1'b0;
    logic        p_dir = 1'b0;
    logic [31:0] p_in = '0;
    logic [31:0] p_d = '0;
    logic [3:0]  p_f = '0;
    string       p_tag = "";

    always #10 clk = ~clk;

    hsc_converter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .to_half(to_half), .din(din),
        .out_valid(out_valid), .dout(dout), .flg_invalid(flg_invalid),
        .flg_overflow(flg_overflow), .flg_underflow(flg_underflow), .flg_inexact(flg_inexact)
    );

    function automatic real pow2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    // expected flags are packed as {invalid, overflow, underflow, inexact}
    function automatic void ref_h2s(input logic [15:0] h, output logic [31:0] r,
                                    output logic [3:0] f, output string tag);
        logic [63:0] b;
        real v;
        f = 4'b0000;
        tag = "R1";
        if (h[14:10] == 5'h1F && h[9:0] == 0) begin
            r = {h[15], 8'hFF, 23'h0}; tag = "R2";
        end else if (h[14:10] == 5'h1F) begin
            r = {h[15], 8'hFF, h[9:8], 13'h0, h[7:0]};
            f[3] = ~h[9];
            tag = h[9] ? "R3" : "R5";
        end else if (h[14:0] == 0) begin
            r = {h[15], 31'h0};
        end else begin
            if (h[14:10] == 0) v = real'(h[9:0]) * pow2(-24);
            else v = real'(1024 + int'(h[9:0])) * pow2(int'(h[14:10]) - 25);
            b = $realtobits(v);
            r = {h[15], 8'(int'(b[62:52]) - 1023 + 127), b[51:29]};
        end
    endfunction

    function automatic void ref_s2h(input logic [31:0] s, output logic [31:0] r,
                                    output logic [3:0] f, output string tag);
        logic [63:0] b;
        real v, ulp, q, fr, rv;
        int lg, ip, rl;
        logic [9:0] pay;
        f = 4'b0000;
        tag = "R6";
        r = '0;
        if (s[30:23] == 8'hFF && s[22:0] == 0) begin
            r = {16'h0, s[31], 5'h1F, 10'h0}; tag = "R2";
        end else if (s[30:23] == 8'hFF) begin
            pay = {s[22:21], s[7:0]};
            if (pay == 0) pay[8] = 1'b1;
            r = {16'h0, s[31], 5'h1F, pay};
            f[3] = ~s[22];
            tag = s[22] ? "R4" : "R5";
        end else begin
            if (s[30:23] == 0) v = real'(s[22:0]) * pow2(-149);
            else v = real'(8388608 + int'(s[22:0])) * pow2(int'(s[30:23]) - 150);
            if (v == 0.0) begin
                r = {16'h0, s[31], 15'h0};
            end else begin
                b = $realtobits(v);
                lg = int'(b[62:52]) - 1023;
                ulp = (lg < -14) ? pow2(-24) : pow2(lg - 10);
                q = v / ulp;
                ip = $rtoi(q);
                fr = q - real'(ip);
                if (fr > 0.5 || (fr == 0.5 && (ip % 2) == 1)) ip = ip + 1;
                rv = real'(ip) * ulp;
                f[0] = (fr != 0.0);
                if (rv >= 65536.0) begin
                    r = {16'h0, s[31], 5'h1F, 10'h0};
                    f[2] = 1'b1; f[0] = 1'b1; tag = "R7";
                end else begin
                    if (rv == 0.0) r = {16'h0, s[31], 15'h0};
                    else begin
                        b = $realtobits(rv);
                        rl = int'(b[62:52]) - 1023;
                        if (rl >= -14) r = {16'h0, s[31], 5'(rl + 15), b[51:42]};
                        else r = {16'h0, s[31], 5'h0, 10'(ip)};
                    end
                    if (f[0] && lg < -14) begin f[1] = 1'b1; tag = "R8"; end
                end
            end
        end
    endfunction

    task automatic check_pending();
        logic [3:0] got_f;
        got_f = {flg_invalid, flg_overflow, flg_underflow, flg_inexact};
        n_chk++;
        if (!out_valid || dout !== p_d || got_f !== p_f) begin
            n_fail++;
            $display("FAIL %s in=%h dir=%0d: got v=%0d d=%h f=%b, expected v=1 d=%h f=%b",
                     p_tag, p_in, p_dir, out_valid, dout, got_f, p_d, p_f);
        end
        if (p_dir) begin
            n_chk++;
            // R11: half results leave the upper word clear
            if (dout[31:16] !== 16'h0) begin
                n_fail++;
                $display("FAIL R11 in=%h: got upper=%h, expected 0000", p_in, dout[31:16]);
            end
        end
    endtask

    // one operand per falling edge; the previous operand's result is checked first
    task automatic push(input logic dir, input logic [31:0] w);
        logic [31:0] e; logic [3:0] f; string tg;
        @(negedge clk);
        if (p_on) check_pending();
        if (dir) ref_s2h(w, e, f, tg); else ref_h2s(w[15:0], e, f, tg);
        in_valid = 1'b1; to_half = dir; din = w;
        p_on = 1'b1; p_dir = dir; p_in = w; p_d = e; p_f = f; p_tag = tg;
    endtask

    task automatic idle_one();
        @(negedge clk);
        if (p_on) check_pending();
        p_on = 1'b0;
        in_valid = 1'b0; din = 32'hFFFF_FFFF;
        @(negedge clk);
        n_chk++;
        // R9: an idle cycle clears valid, data and flags
        if (out_valid || dout != 0 || flg_invalid || flg_overflow || flg_underflow || flg_inexact) begin
            n_fail++;
            $display("FAIL R9 idle: got v=%0d d=%h, expected v=0 d=00000000 flags 0", out_valid, dout);
        end
    endtask

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        n_chk++;
        // R10: reset state
        if (out_valid || dout != 0 || flg_invalid || flg_overflow || flg_underflow || flg_inexact) begin
            n_fail++;
            $display("FAIL R10 reset: got v=%0d d=%h, expected all zero", out_valid, dout);
        end
        rst_n = 1'b1;
        // R1 R2 R3 R5: every half code, widened
        for (int h = 0; h < 65536; h++) push(1'b0, {16'hABCD, 16'(h)});
        idle_one();
        // R4 R5 R6 R7 R8: directed narrowing corners
        push(1'b1, 32'h477FE000); push(1'b1, 32'h477FF000); push(1'b1, 32'h477FEFFF);
        push(1'b1, 32'hC77FF000); push(1'b1, 32'h7F7FFFFF); push(1'b1, 32'h33800000);
        push(1'b1, 32'h33000000); push(1'b1, 32'h33000001); push(1'b1, 32'h38800000);
        push(1'b1, 32'h387FF000); push(1'b1, 32'h387FE000); push(1'b1, 32'h00000001);
        push(1'b1, 32'h80000000); push(1'b1, 32'h3F801000); push(1'b1, 32'h3F803000);
        push(1'b1, 32'h7FC00000); push(1'b1, 32'h7F800001); push(1'b1, 32'h7F800100);
        push(1'b1, 32'hFFA00000); push(1'b1, 32'h7F800000); push(1'b1, 32'hFF800000);
        push(1'b1, 32'h33C00000); push(1'b1, 32'h80400000);
        idle_one();
        for (int k = 0; k < 12000; k++) push(1'b1, $urandom);
        for (int k = 0; k < 16000; k++) begin
            w = $urandom;
            w[30:23] = 8'(96 + ($urandom % 48));
            push(1'b1, w);
        end
        idle_one();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule